// File: doc/BRIEF.md
# Wormhole Output Port with Virtual Channels

This block is the output half of one router port. Several inputs offer flits to it, each flit marked as the start of a packet, the end of a packet, both (a one-flit packet) or neither (a middle flit). A packet may leave only after it holds a virtual channel on the output link. Its first flit claims a free channel, and the packet keeps that channel until its last flit has gone. Middle flits carry no routing information, so a channel never carries flits of two packets mixed together.

All virtual channels share one physical link. In each cycle one flit may go out, picked in rotation from the channels that have a waiting flit and at least one downstream credit. Every outgoing flit is tagged with its channel number. The downstream buffer gives a credit back for each slot it frees. A channel with no credits is passed over, so the other channels keep the link busy. Downstream buffers hold only a few flits, and a packet may be longer than that. Route computation and the crossbar sit outside this block: each input here already targets this output.

Top module: `wvc_outport`

## Requirements
- R1: After reset out_valid is 0, every in_ready bit is 0, every virtual channel is free and every credit counter holds CRED_MAX.
- R2: Flit marking: in_head=1 with in_tail=0 is a first flit, in_head=0 with in_tail=1 is a last flit, both 1 is a one-flit packet, both 0 is a middle flit. out_head, out_tail and out_data repeat the values of the flit that was sent. out_vc holds the channel index, 0 to N_VC-1.
- R3: A first flit from an input that holds no channel asks for one. At most one channel is granted per cycle. If a channel is free and has credit, the first flit shows on the output two clock edges after it is first offered.
- R4: A channel belongs to at most one packet at a time, and an input holds at most one channel. Between a packet's first and last flit, its channel carries only that packet's flits, in order.
- R5: A channel becomes free on the clock edge that sends its last flit. Another packet can be granted it from the next cycle.
- R6: At most one flit leaves per cycle. in_ready is set only for the input whose flit is sent in that cycle, and only while that input's in_valid is 1. While channels stay eligible, the link sends on every cycle.
- R7: Link arbitration rotates among the eligible channels. Two channels that stay eligible alternate flit by flit.
- R8: Each channel's counter starts at CRED_MAX. It drops by one for each flit sent on that channel and rises by one for each cred_ret pulse. No more than CRED_MAX flits of a channel are ever waiting for their credit.
- R9: A channel with zero credits is skipped, and packets on other channels keep flowing and finish.
- R10: A flit that is not a first flit, offered by an input that holds no channel, is ignored: in_ready stays 0 for it and nothing is sent.
- R11: Channel grants rotate among the requesting inputs. When more packets wait than there are channels, every packet is still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N_IN | Input i offers a flit |
| in_head | input | N_IN | Offered flit is the first of its packet |
| in_tail | input | N_IN | Offered flit is the last of its packet |
| in_data | input | N_IN*DATA_W | Payloads, input i in bits [i*DATA_W +: DATA_W] |
| in_ready | output | N_IN | Input i's flit is taken in this cycle |
| cred_ret | input | N_VC | One credit returned per set bit |
| out_valid | output | 1 | A flit is on the link |
| out_vc | output | max(1,clog2(N_VC)) | Channel tag of the link flit |
| out_head | output | 1 | Link flit is a first flit |
| out_tail | output | 1 | Link flit is a last flit |
| out_data | output | DATA_W | Link flit payload |

## Verification
Two things often happen on the same clock edge. A last flit frees its channel while a grant goes to another waiting input, and the link also sends on a different channel. The test with four inputs and two channels makes this happen again and again. The bench follows each channel from the outside and records which packet currently owns it. Any out-of-order flit, a first flit on a channel that is still owned, or one input owning two channels counts as a failure. Credit starvation is forced by holding back returns for channel 0 alone: the packet on channel 1 must still finish, and channel 0 must stop after exactly CRED_MAX flits.

// File: rtl/wvc_pkg.sv
package wvc_pkg;

    // Width of an index into n items, never below one bit.
    function automatic int idx_w(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Flit marking as {head, tail}.
    typedef enum logic [1:0] {
        FL_MID    = 2'b00,
        FL_LAST   = 2'b01,
        FL_FIRST  = 2'b10,
        FL_SINGLE = 2'b11
    } flit_kind_e;

endpackage

// File: rtl/wvc_rr_pick.sv
module wvc_rr_pick
    import wvc_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0]           req,
    input  logic [idx_w(N)-1:0]    ptr,
    output logic                   any,
    output logic [idx_w(N)-1:0]    idx
);
    localparam int W = idx_w(N);

    // Scan from the highest offset down so the request closest to ptr wins.
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int off = N - 1; off >= 0; off--) begin
            int cand;
            cand = (int'(ptr) + off) % N;
            if (req[cand]) begin
                any = 1'b1;
                idx = W'(cand);
            end
        end
    end
endmodule

// File: rtl/wvc_credit.sv
module wvc_credit #(
    parameter int N_VC     = 2,
    parameter int CRED_MAX = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_VC-1:0] dec,
    input  logic [N_VC-1:0] inc,
    output logic [N_VC-1:0] ok
);
    localparam int CW = $clog2(CRED_MAX + 1);

    typedef struct packed {
        logic [N_VC-1:0][CW-1:0] cnt;
    } cred_st_t;

    cred_st_t cs_d, cs_q;

    always_comb begin
        cs_d = cs_q;
        for (int v = 0; v < N_VC; v++) begin
            cs_d.cnt[v] = cs_q.cnt[v] - CW'(dec[v]) + CW'(inc[v]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int v = 0; v < N_VC; v++) begin
                cs_q.cnt[v] <= CW'(CRED_MAX);
            end
        end else begin
            cs_q <= cs_d;
        end
    end

    for (genvar v = 0; v < N_VC; v++) begin : g_ok
        assign ok[v] = (cs_q.cnt[v] != '0);
    end
endmodule

// File: rtl/wvc_outport.sv
module wvc_outport
    import wvc_pkg::*;
#(
    parameter int N_IN     = 4,
    parameter int N_VC     = 2,
    parameter int CRED_MAX = 4,
    parameter int DATA_W   = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_IN-1:0]           in_valid,
    input  logic [N_IN-1:0]           in_head,
    input  logic [N_IN-1:0]           in_tail,
    input  logic [N_IN*DATA_W-1:0]    in_data,
    output logic [N_IN-1:0]           in_ready,
    input  logic [N_VC-1:0]           cred_ret,
    output logic                      out_valid,
    output logic [idx_w(N_VC)-1:0]    out_vc,
    output logic                      out_head,
    output logic                      out_tail,
    output logic [DATA_W-1:0]         out_data
);
    localparam int IW = idx_w(N_IN);
    localparam int VW = idx_w(N_VC);

    typedef struct packed {
        logic [N_VC-1:0]          vc_busy;
        logic [N_VC-1:0][IW-1:0]  vc_owner;
        logic [N_IN-1:0]          in_bound;
        logic [IW-1:0]            in_ptr;
        logic [VW-1:0]            vc_ptr;
        logic [VW-1:0]            link_ptr;
        logic                     o_valid;
        logic [VW-1:0]            o_vc;
        logic                     o_head;
        logic                     o_tail;
        logic [DATA_W-1:0]        o_data;
    } port_st_t;

    port_st_t st_d, st_q;

    function automatic logic [IW-1:0] in_after(logic [IW-1:0] k);
        return (int'(k) >= N_IN - 1) ? '0 : IW'(int'(k) + 1);
    endfunction

    function automatic logic [VW-1:0] vc_after(logic [VW-1:0] k);
        return (int'(k) >= N_VC - 1) ? '0 : VW'(int'(k) + 1);
    endfunction

    // Requests seen by the two arbiters.
    logic [N_IN-1:0] alloc_req;
    logic [N_VC-1:0] vc_free;
    logic [N_VC-1:0] link_req;
    logic [N_VC-1:0] cred_ok;
    logic [N_VC-1:0] cred_dec;

    logic            in_any, free_any, link_any;
    logic [IW-1:0]   in_idx;
    logic [VW-1:0]   free_idx, link_idx;
    logic [IW-1:0]   send_src;

    assign alloc_req = in_valid & in_head & ~st_q.in_bound;
    assign vc_free   = ~st_q.vc_busy;

    for (genvar v = 0; v < N_VC; v++) begin : g_link_req
        assign link_req[v] = st_q.vc_busy[v] & in_valid[st_q.vc_owner[v]] & cred_ok[v];
        assign cred_dec[v] = link_any && (int'(link_idx) == v);
    end

    wvc_rr_pick #(.N(N_IN)) u_in_pick (
        .req (alloc_req),
        .ptr (st_q.in_ptr),
        .any (in_any),
        .idx (in_idx)
    );

    wvc_rr_pick #(.N(N_VC)) u_vc_pick (
        .req (vc_free),
        .ptr (st_q.vc_ptr),
        .any (free_any),
        .idx (free_idx)
    );

    wvc_rr_pick #(.N(N_VC)) u_link_pick (
        .req (link_req),
        .ptr (st_q.link_ptr),
        .any (link_any),
        .idx (link_idx)
    );

    wvc_credit #(.N_VC(N_VC), .CRED_MAX(CRED_MAX)) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .dec   (cred_dec),
        .inc   (cred_ret),
        .ok    (cred_ok)
    );

    assign send_src = st_q.vc_owner[link_idx];

    for (genvar i = 0; i < N_IN; i++) begin : g_ready
        assign in_ready[i] = link_any && (int'(send_src) == i);
    end

    always_comb begin
        flit_kind_e kind;
        st_d         = st_q;
        st_d.o_valid = 1'b0;
        st_d.o_head  = 1'b0;
        st_d.o_tail  = 1'b0;
        kind         = flit_kind_e'({in_head[send_src], in_tail[send_src]});

        // Channel grant: one waiting first flit gets one free channel.
        if (in_any && free_any) begin
            st_d.vc_busy[free_idx]  = 1'b1;
            st_d.vc_owner[free_idx] = in_idx;
            st_d.in_bound[in_idx]   = 1'b1;
            st_d.in_ptr             = in_after(in_idx);
            st_d.vc_ptr             = vc_after(free_idx);
        end

        // Link: send one flit from the chosen channel; a last flit frees it.
        if (link_any) begin
            st_d.o_valid  = 1'b1;
            st_d.o_vc     = link_idx;
            st_d.o_head   = in_head[send_src];
            st_d.o_tail   = in_tail[send_src];
            st_d.o_data   = in_data[int'(send_src)*DATA_W +: DATA_W];
            st_d.link_ptr = vc_after(link_idx);
            if (kind == FL_LAST || kind == FL_SINGLE) begin
                st_d.vc_busy[link_idx] = 1'b0;
                st_d.in_bound[send_src] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.o_valid;
    assign out_vc    = st_q.o_vc;
    assign out_head  = st_q.o_head;
    assign out_tail  = st_q.o_tail;
    assign out_data  = st_q.o_data;
endmodule

// File: rtl/wvc_outport_chk.sv
module wvc_outport_chk
    import wvc_pkg::*;
#(
    parameter int N_IN     = 4,
    parameter int N_VC     = 2,
    parameter int CRED_MAX = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_IN-1:0]           in_valid,
    input  logic [N_IN-1:0]           in_ready,
    input  logic [N_VC-1:0]           cred_ret,
    input  logic                      out_valid,
    input  logic [idx_w(N_VC)-1:0]    out_vc,
    input  logic                      out_tail,
    input  logic [N_VC-1:0]           vc_busy,
    input  logic [N_VC*idx_w(N_IN)-1:0] vc_owner,
    input  logic [N_IN-1:0]           in_bound
);
    localparam int IW = idx_w(N_IN);
    localparam int OW = $clog2(CRED_MAX + 1) + 2;

    // Flits on the link per channel still waiting for their credit.
    logic [N_VC-1:0][OW-1:0] occ_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            for (int v = 0; v < N_VC; v++) begin
                occ_q[v] <= occ_q[v]
                          + OW'(out_valid && (int'(out_vc) == v))
                          - OW'(cred_ret[v]);
            end
        end
    end

    // Number of busy channels each input owns.
    int bound_cnt [N_IN];
    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            bound_cnt[i] = 0;
            for (int v = 0; v < N_VC; v++) begin
                if (vc_busy[v] && (int'(vc_owner[v*IW +: IW]) == i)) begin
                    bound_cnt[i] = bound_cnt[i] + 1;
                end
            end
        end
    end

    // R6
    one_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready));

    // R6
    ready_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready & ~in_valid) == '0);

    // R5
    tail_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_tail) |-> !vc_busy[out_vc]);

    for (genvar v = 0; v < N_VC; v++) begin : g_occ
        // R8
        credit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            occ_q[v] <= OW'(CRED_MAX));
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_bind
        // R4
        owner_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
            bound_cnt[i] == (in_bound[i] ? 1 : 0));
    end

    for (genvar a = 0; a < N_VC; a++) begin : g_a
        for (genvar b = a + 1; b < N_VC; b++) begin : g_b
            // R4
            excl_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (vc_busy[a] && vc_busy[b]) |->
                (vc_owner[a*IW +: IW] != vc_owner[b*IW +: IW]));
        end
    end
endmodule

bind wvc_outport wvc_outport_chk #(
    .N_IN     (N_IN),
    .N_VC     (N_VC),
    .CRED_MAX (CRED_MAX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .cred_ret  (cred_ret),
    .out_valid (out_valid),
    .out_vc    (out_vc),
    .out_tail  (out_tail),
    .vc_busy   (st_q.vc_busy),
    .vc_owner  (st_q.vc_owner),
    .in_bound  (st_q.in_bound)
);

// File: tb/sim_wvc_outport.sv
module sim_wvc_outport;
    import wvc_pkg::*;

    localparam int N_IN     = 4;
    localparam int N_VC     = 2;
    localparam int CRED_MAX = 4;
    localparam int DATA_W   = 16;
    localparam int VW       = idx_w(N_VC);

    logic clk   = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [N_IN-1:0]        in_valid = '0;
    logic [N_IN-1:0]        in_head  = '0;
    logic [N_IN-1:0]        in_tail  = '0;
    logic [N_IN*DATA_W-1:0] in_data  = '0;
    logic [N_IN-1:0]        in_ready;
    logic [N_VC-1:0]        cred_ret = '0;
    logic                   out_valid, out_head, out_tail;
    logic [VW-1:0]          out_vc;
    logic [DATA_W-1:0]      out_data;

    wvc_outport #(
        .N_IN(N_IN), .N_VC(N_VC), .CRED_MAX(CRED_MAX), .DATA_W(DATA_W)
    ) u0 (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_head(in_head), .in_tail(in_tail),
        .in_data(in_data), .in_ready(in_ready), .cred_ret(cred_ret),
        .out_valid(out_valid), .out_vc(out_vc), .out_head(out_head),
        .out_tail(out_tail), .out_data(out_data)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-input sources: {head, tail, data}; data = {src[3:0], pkt[7:0], idx[3:0]}.
    logic [DATA_W+1:0] srcq [N_IN][$];
    bit ready_seen [N_IN];

    always @(negedge clk) begin
        for (int i = 0; i < N_IN; i++) begin
            if (srcq[i].size() != 0) begin
                in_valid[i] <= 1'b1;
                {in_head[i], in_tail[i], in_data[i*DATA_W +: DATA_W]} <= srcq[i][0];
            end else begin
                in_valid[i] <= 1'b0;
                in_head[i]  <= 1'b0;
                in_tail[i]  <= 1'b0;
                in_data[i*DATA_W +: DATA_W] <= '0;
            end
        end
    end

    // Take a flit off its source just before the edge that accepts it.
    initial begin
        forever begin
            @(negedge clk);
            #3;
            for (int i = 0; i < N_IN; i++) begin
                if (in_ready[i]) ready_seen[i] = 1'b1;
                if (in_valid[i] && in_ready[i] && srcq[i].size() != 0)
                    void'(srcq[i].pop_front());
            end
        end
    end

    // Link monitor and downstream credit model.
    int  vc_open [N_VC];
    int  cur_src [N_VC];
    int  cur_pkt [N_VC];
    int  nxt_idx [N_VC];
    int  sent_cnt[N_VC];
    int  pend    [N_VC];
    int  outst   [N_VC];
    bit  hold    [N_VC];
    int  src_vc  [N_IN];
    int  done_cnt = 0;
    int  tot_out  = 0;
    int  cyc      = 0;
    int  seq_vc[$];
    int  seq_cyc[$];

    initial begin
        for (int v = 0; v < N_VC; v++) begin
            vc_open[v] = 0; cur_src[v] = 0; cur_pkt[v] = 0; nxt_idx[v] = 0;
            sent_cnt[v] = 0; pend[v] = 0; outst[v] = 0; hold[v] = 1'b0;
        end
        for (int i = 0; i < N_IN; i++) begin
            src_vc[i] = -1;
            ready_seen[i] = 1'b0;
        end
    end

    always @(negedge clk) begin
        int v, s, p, k, want;
        logic [N_VC-1:0] ret;
        cyc++;
        ret = '0;
        for (int w = 0; w < N_VC; w++) begin
            want = pend[w] + ((rst_n && out_valid && int'(out_vc) == w) ? 1 : 0);
            if (!hold[w] && want > 0) begin
                ret[w] = 1'b1;
                pend[w] = want - 1;
            end else begin
                pend[w] = want;
            end
        end
        if (rst_n && out_valid) begin
            v = int'(out_vc);
            s = int'(out_data[15:12]);
            p = int'(out_data[11:4]);
            k = int'(out_data[3:0]);
            tot_out++;
            sent_cnt[v]++;
            seq_vc.push_back(v);
            seq_cyc.push_back(cyc);
            outst[v]++;
            check(outst[v] <= CRED_MAX, "R8", "flits awaiting credit", outst[v], CRED_MAX);
            if (out_head) begin
                check(vc_open[v] == 0, "R4", "first flit on owned channel", vc_open[v], 0);
                check(src_vc[s] < 0, "R4", "input owns a second channel", src_vc[s], -1);
                check(k == 0, "R4", "first flit index", k, 0);
                vc_open[v] = 1;
                cur_src[v] = s;
                cur_pkt[v] = p;
                src_vc[s]  = v;
            end else begin
                check(vc_open[v] == 1 && cur_src[v] == s && cur_pkt[v] == p && nxt_idx[v] == k,
                      "R4", "flit order within channel", k, nxt_idx[v]);
            end
            nxt_idx[v] = k + 1;
            if (out_tail) begin
                vc_open[v] = 0;
                src_vc[s]  = -1;
                done_cnt++;
            end
        end
        for (int w = 0; w < N_VC; w++) begin
            if (ret[w]) outst[w]--;
        end
        cred_ret <= ret;
    end

    task automatic push_pkt(int src, int pkt, int len);
        for (int k = 0; k < len; k++) begin
            srcq[src].push_back({(k == 0), (k == len - 1), 4'(src), 8'(pkt), 4'(k)});
        end
    endtask

    task automatic wait_done(int target, int maxc, string req);
        int c = 0;
        while (done_cnt < target && c < maxc) begin
            @(negedge clk);
            c++;
        end
        check(done_cnt >= target, req, "packets delivered", done_cnt, target);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == '0, "R1", "in_ready after reset", int'(in_ready), 0);
    endtask

    task automatic t_single();
        int base;
        base = done_cnt;
        @(negedge clk); #1;
        push_pkt(2, 1, 1);
        @(negedge clk);                       // flit now offered
        @(negedge clk);
        check(out_valid == 1'b0, "R3", "sent one edge after offer", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid == 1'b1, "R3", "sent two edges after offer", int'(out_valid), 1);
        check(out_head && out_tail, "R2", "one-flit packet marks", int'({out_head, out_tail}), 3);
        check(out_data == 16'h2010, "R2", "payload", int'(out_data), 16'h2010);
        check(int'(out_vc) < N_VC, "R2", "channel tag range", int'(out_vc), 0);
        wait_done(base + 1, 20, "R3");
        // Three packets over two channels: a channel must be reused.
        @(negedge clk); #1;
        push_pkt(0, 1, 3);
        push_pkt(1, 1, 3);
        push_pkt(3, 1, 3);
        wait_done(base + 4, 60, "R5");
        idle(6);
    endtask

    task automatic t_interleave();
        int base, same;
        base = done_cnt;
        seq_vc.delete();
        seq_cyc.delete();
        @(negedge clk); #1;
        push_pkt(0, 2, 8);
        push_pkt(1, 2, 8);
        wait_done(base + 2, 80, "R7");
        check(seq_vc.size() == 16, "R6", "flits on link", seq_vc.size(), 16);
        if (seq_vc.size() == 16) begin
            same = 0;
            for (int j = 1; j < 16; j++) if (seq_vc[j] == seq_vc[j-1]) same++;
            check(same == 0, "R7", "back-to-back flits on one channel", same, 0);
            check(seq_cyc[15] - seq_cyc[0] == 15, "R6", "cycles spanned by 16 flits",
                  seq_cyc[15] - seq_cyc[0] + 1, 16);
        end
        idle(6);
    endtask

    task automatic t_oversub();
        int base;
        base = done_cnt;
        @(negedge clk); #1;
        for (int i = 0; i < N_IN; i++) push_pkt(i, 3, 5);
        wait_done(base + 4, 200, "R11");
        for (int i = 0; i < N_IN; i++)
            check(srcq[i].size() == 0, "R11", "source drained", srcq[i].size(), 0);
        idle(6);
    endtask

    task automatic t_credit();
        int base;
        base = done_cnt;
        hold[0] = 1'b1;
        for (int v = 0; v < N_VC; v++) sent_cnt[v] = 0;
        @(negedge clk); #1;
        push_pkt(1, 4, 10);
        push_pkt(3, 4, 10);
        idle(60);
        check(sent_cnt[0] == CRED_MAX, "R8", "flits on starved channel", sent_cnt[0], CRED_MAX);
        check(sent_cnt[1] == 10, "R9", "flits on other channel", sent_cnt[1], 10);
        check(done_cnt == base + 1, "R9", "packets done while starved", done_cnt - base, 1);
        hold[0] = 1'b0;
        wait_done(base + 2, 80, "R8");
        idle(8);
    endtask

    task automatic t_ignore();
        int base_out, base;
        base_out = tot_out;
        @(negedge clk); #1;
        ready_seen[0] = 1'b0;
        srcq[0].push_back({1'b0, 1'b0, 16'h0ABC});
        idle(10);
        check(ready_seen[0] == 1'b0, "R10", "stray middle flit taken", int'(ready_seen[0]), 0);
        check(tot_out == base_out, "R10", "flits sent for stray flit", tot_out - base_out, 0);
        #1;
        srcq[0].delete();
        idle(3);
        base = done_cnt;
        @(negedge clk); #1;
        push_pkt(0, 5, 2);
        wait_done(base + 1, 30, "R10");
        idle(4);
    endtask

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_interleave();
        t_oversub();
        t_credit();
        t_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule